// File: doc/BRIEF.md
# Iterative 64-bit Integer Multiplier

This block performs the integer multiply operations of a RISC-V core with a 64-bit datapath. It returns the low half of the product, the high half for three signedness combinations (both operands signed, first signed with second unsigned, both unsigned), and a word multiply that works on 32-bit operands and sign-extends the result to 64 bits. The execute stage presents two operands, an operation code and a one-cycle start strobe. After a fixed number of cycles the block pulses a done strobe and presents the result, which holds until the next operation completes.

Only one unsigned product is ever formed. It is built over several cycles, one partial-product row per cycle, with each row covering one slice of the second operand. The signed high halves come from the unsigned high half, minus the other operand wherever an operand's sign bit is set. No signed multiplier is used. When a core running in 32-bit mode issues the word operation, the block raises an illegal flag and returns zero. It does the same for an unused operation code.

Top module: `rv_mult_unit`

## Requirements
- R1: After reset, done_o, busy_o and illegal_o are 0 and result_o is all zeros.
- R2: A start accepted while idle sets busy_o on the next cycle. done_o is high for exactly one cycle, XLEN/ROW_W clock edges after the accepting edge (4 with defaults), and busy_o falls on the same edge.
- R3: Operation code 0 returns the low XLEN bits of a_i × b_i.
- R4: Operation code 1 returns the upper XLEN bits of the product with both operands taken as two's complement.
- R5: Operation code 2 returns the upper XLEN bits of the product with a_i taken as signed and b_i as unsigned.
- R6: Operation code 3 returns the upper XLEN bits of the product with both operands taken as unsigned.
- R7: Operation code 4 (word multiply) with mode32_i low multiplies bits 31:0 of both operands and returns the low 32 bits of the product, sign-extended from bit 31 to XLEN bits.
- R8: Operation code 4 with mode32_i high at the accepting start returns result_o = 0 with illegal_o = 1. Codes 0 to 3 with mode32_i high complete normally with illegal_o = 0.
- R9: Operation codes 5, 6 and 7 return result_o = 0 with illegal_o = 1.
- R10: A start strobe while busy_o is high is ignored. The running operation finishes with its own result and timing, and no extra done pulse follows.
- R11: result_o and illegal_o change only on the edge that raises done_o, and stay steady until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| op_i | input | 3 | Operation code (0 low, 1 high s×s, 2 high s×u, 3 high u×u, 4 word) |
| mode32_i | input | 1 | Core runs in 32-bit mode; makes the word operation illegal |
| a_i | input | XLEN | First operand |
| b_i | input | XLEN | Second operand |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | XLEN | Result of the last completed operation |
| illegal_o | output | 1 | Last completed operation was illegal |

## Verification
The assertions take for granted that start_i is only meaningful while the block is idle. When start_i is high during busy_o, they require that no new latency window opens. They also assume that op_i and mode32_i matter only at the accepting edge. The checker therefore latches the operation code itself to judge word sign extension. The stimulus raises start_i for one cycle at a time and changes operands between negative clock edges. It raises start_i during busy_o only on purpose, in the test for ignored starts.

// File: rtl/rv_mult_pkg.sv
package rv_mult_pkg;

   typedef enum logic [2:0] {
      MOP_LOW  = 3'd0,
      MOP_HSS  = 3'd1,
      MOP_HSU  = 3'd2,
      MOP_HUU  = 3'd3,
      MOP_WORD = 3'd4
   } mop_e;

endpackage

// File: rtl/rv_mult_row.sv
// One partial-product row: full operand times one slice of the multiplier.
module rv_mult_row #(
   parameter int XLEN  = 64,
   parameter int ROW_W = 16
) (
   input  logic [XLEN-1:0]       a,
   input  logic [ROW_W-1:0]      b_seg,
   output logic [XLEN+ROW_W-1:0] pp
);
   localparam int PW = XLEN + ROW_W;

   logic [PW-1:0] ax;
   logic [PW-1:0] bx;

   assign ax = PW'(a);
   assign bx = PW'(b_seg);
   assign pp = ax * bx;
endmodule

// File: rtl/rv_mult_fix.sv
// Derives every result variant from the single unsigned product.
module rv_mult_fix #(
   parameter int XLEN = 64
) (
   input  logic [2*XLEN-1:0] prod,
   input  logic [XLEN-1:0]   a,
   input  logic [XLEN-1:0]   b,
   input  logic [2:0]        op,
   input  logic              bad,
   output logic [XLEN-1:0]   res
);
   import rv_mult_pkg::*;

   logic [XLEN-1:0] hi;
   logic [XLEN-1:0] corr_a;
   logic [XLEN-1:0] corr_b;
   logic [XLEN-1:0] word_res;

   assign hi     = prod[2*XLEN-1:XLEN];
   // signed a contributes -b * 2^XLEN when negative; same for b
   assign corr_a = a[XLEN-1] ? b : '0;
   assign corr_b = b[XLEN-1] ? a : '0;

   generate
      if (XLEN > 32) begin : g_word
         assign word_res = {{(XLEN-32){prod[31]}}, prod[31:0]};
      end else begin : g_noword
         assign word_res = '0;
      end
   endgenerate

   always_comb begin
      case (op)
         MOP_LOW:  res = prod[XLEN-1:0];
         MOP_HSS:  res = hi - corr_a - corr_b;
         MOP_HSU:  res = hi - corr_a;
         MOP_HUU:  res = hi;
         MOP_WORD: res = word_res;
         default:  res = '0;
      endcase
      if (bad) res = '0;
   end
endmodule

// File: rtl/rv_mult_unit.sv
module rv_mult_unit #(
   parameter int XLEN  = 64,
   parameter int ROW_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [2:0]      op_i,
   input  logic            mode32_i,
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [XLEN-1:0] result_o,
   output logic            illegal_o
);
   import rv_mult_pkg::*;

   localparam int ROWS    = XLEN / ROW_W;
   localparam int CW      = $clog2(ROWS + 1);
   localparam int PW      = XLEN + ROW_W;
   localparam bit WORD_EN = (XLEN > 32);

   generate
      if (XLEN % ROW_W != 0) begin : g_bad_row
         $error("ROW_W must divide XLEN evenly");
      end
      if (XLEN < 32) begin : g_bad_xlen
         $error("XLEN must be at least 32");
      end
      if (ROWS < 2) begin : g_bad_rows
         $error("at least two rows are required");
      end
   endgenerate

   logic              busy_q;
   logic [CW-1:0]     cnt_q;
   logic [XLEN-1:0]   a_q;
   logic [XLEN-1:0]   b_q;
   logic [2:0]        op_q;
   logic              bad_q;
   logic [2*XLEN-1:0] acc_q;
   logic              done_q;
   logic [XLEN-1:0]   res_q;
   logic              ill_q;

   logic [ROW_W-1:0]  b_seg;
   logic [PW-1:0]     pp;
   logic [2*XLEN-1:0] pp_sh;
   logic [2*XLEN-1:0] sum;
   logic [XLEN-1:0]   fix_res;
   logic              last_row;
   logic              bad_in;

   assign bad_in   = ((op_i == MOP_WORD) && (mode32_i || !WORD_EN)) || (op_i > 3'd4);
   assign b_seg    = b_q[cnt_q*ROW_W +: ROW_W];
   assign pp_sh    = (2*XLEN)'(pp) << (cnt_q * ROW_W);
   assign sum      = acc_q + pp_sh;
   assign last_row = (cnt_q == CW'(ROWS - 1));

   rv_mult_row #(.XLEN(XLEN), .ROW_W(ROW_W)) u_row (
      .a     (a_q),
      .b_seg (b_seg),
      .pp    (pp)
   );

   rv_mult_fix #(.XLEN(XLEN)) u_fix (
      .prod (sum),
      .a    (a_q),
      .b    (b_q),
      .op   (op_q),
      .bad  (bad_q),
      .res  (fix_res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         a_q    <= '0;
         b_q    <= '0;
         op_q   <= '0;
         bad_q  <= 1'b0;
         acc_q  <= '0;
         done_q <= 1'b0;
         res_q  <= '0;
         ill_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start_i) begin
               busy_q <= 1'b1;
               cnt_q  <= '0;
               a_q    <= a_i;
               b_q    <= b_i;
               op_q   <= op_i;
               bad_q  <= bad_in;
               acc_q  <= '0;
            end
         end else begin
            acc_q <= sum;
            cnt_q <= cnt_q + 1'b1;
            if (last_row) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               res_q  <= fix_res;
               ill_q  <= bad_q;
            end
         end
      end
   end

   assign busy_o    = busy_q;
   assign done_o    = done_q;
   assign result_o  = res_q;
   assign illegal_o = ill_q;
endmodule

// File: rtl/rv_mult_unit_chk.sv
module rv_mult_unit_chk #(
   parameter int XLEN  = 64,
   parameter int ROW_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic [2:0]      op_i,
   input logic            busy_o,
   input logic            done_o,
   input logic [XLEN-1:0] result_o,
   input logic            illegal_o
);
   localparam int ROWS = XLEN / ROW_W;
   localparam int LW   = $clog2(ROWS + 2) + 1;

   logic [LW-1:0] lat;
   logic [2:0]    op_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat  <= '0;
         op_l <= '0;
      end else if (start_i && !busy_o) begin
         lat  <= LW'(1);
         op_l <= op_i;
      end else if (lat == LW'(ROWS + 1)) begin
         lat <= '0;
      end else if (lat != '0) begin
         lat <= lat + 1'b1;
      end
   end

   assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);
   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (lat == LW'(ROWS + 1)));
   assert_done_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (lat == LW'(ROWS + 1)) |-> (done_o && !busy_o));
   assert_no_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !done_o);
   assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (result_o == '0));
   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(result_o) && $stable(illegal_o)));

   generate
      if (XLEN > 32) begin : g_word_chk
         assert_word_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && !illegal_o && op_l == 3'd4)
               |-> (result_o[XLEN-1:32] == {(XLEN-32){result_o[31]}}));
      end
   endgenerate
endmodule

bind rv_mult_unit rv_mult_unit_chk #(.XLEN(XLEN), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/tb_rv_mult_unit.sv
`timescale 1ns/1ps
module tb_rv_mult_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic        mode32_i = 1'b0;
   logic [63:0] a_i = '0;
   logic [63:0] b_i = '0;
   logic        busy_o;
   logic        done_o;
   logic [63:0] result_o;
   logic        illegal_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   rv_mult_unit dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .mode32_i(mode32_i), .a_i(a_i), .b_i(b_i), .busy_o(busy_o),
      .done_o(done_o), .result_o(result_o), .illegal_o(illegal_o)
   );

   logic [63:0] corner [9];
   initial begin
      corner[0] = 64'd0;
      corner[1] = 64'd1;
      corner[2] = '1;
      corner[3] = 64'h8000_0000_0000_0000;
      corner[4] = 64'h7FFF_FFFF_FFFF_FFFF;
      corner[5] = 64'h0000_0000_8000_0000;
      corner[6] = 64'h0000_0000_7FFF_FFFF;
      corner[7] = 64'h5555_AAAA_3C3C_C3C3;
      corner[8] = 64'hFFFF_FFFF_0000_0001;
   end

   function automatic logic [63:0] ref_res(logic [2:0] op, logic [63:0] a,
                                           logic [63:0] b, logic m32);
      logic [127:0] sa, sb, ua, ub, p;
      sa = {{64{a[63]}}, a};
      sb = {{64{b[63]}}, b};
      ua = {64'd0, a};
      ub = {64'd0, b};
      case (op)
         3'd0: begin p = ua * ub; return p[63:0]; end
         3'd1: begin p = sa * sb; return p[127:64]; end
         3'd2: begin p = sa * ub; return p[127:64]; end
         3'd3: begin p = ua * ub; return p[127:64]; end
         3'd4: begin
            if (m32) return 64'd0;
            p = {96'd0, a[31:0]} * {96'd0, b[31:0]};
            return {{32{p[31]}}, p[31:0]};
         end
         default: return 64'd0;
      endcase
   endfunction

   function automatic string op_tag(logic [2:0] op, logic m32);
      case (op)
         3'd0: return m32 ? "R3/R8" : "R3";
         3'd1: return m32 ? "R4/R8" : "R4";
         3'd2: return m32 ? "R5/R8" : "R5";
         3'd3: return m32 ? "R6/R8" : "R6";
         3'd4: return m32 ? "R8" : "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Run one operation and check timing, result and illegal flag.
   task automatic run_op(logic [2:0] op, logic [63:0] a, logic [63:0] b, logic m32);
      logic [63:0] exp_r;
      logic        exp_i;
      string       tag;
      exp_r = ref_res(op, a, b, m32);
      exp_i = (op == 3'd4 && m32) || (op > 3'd4);
      tag   = op_tag(op, m32);
      @(negedge clk);
      start_i = 1'b1; op_i = op; a_i = a; b_i = b; mode32_i = m32;
      @(negedge clk);
      start_i = 1'b0; a_i = ~a; b_i = b ^ 64'h1234; op_i = 3'd0; mode32_i = 1'b0;
      check64("R2 busy after accept", {63'd0, busy_o}, 64'd1);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (i < 3) check64("R2 no early done", {63'd0, done_o}, 64'd0);
         else       check64("R2 done on time", {63'd0, done_o}, 64'd1);
      end
      check64(tag, result_o, exp_r);
      check64({tag, " illegal flag"}, {63'd0, illegal_o}, {63'd0, exp_i});
      check64("R2 busy cleared", {63'd0, busy_o}, 64'd0);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [63:0] keep_r;
      logic [63:0] ra, rb;
      repeat (3) @(negedge clk);
      // R1 reset state
      check64("R1 done", {63'd0, done_o}, 64'd0);
      check64("R1 busy", {63'd0, busy_o}, 64'd0);
      check64("R1 illegal", {63'd0, illegal_o}, 64'd0);
      check64("R1 result", result_o, 64'd0);
      rst_n = 1'b1;

      // corner sweep over all legal ops in 64-bit mode
      for (int op = 0; op < 5; op++)
         for (int i = 0; i < 9; i++)
            for (int j = 0; j < 9; j++)
               run_op(3'(op), corner[i], corner[j], 1'b0);

      // random operands
      for (int op = 0; op < 5; op++)
         for (int k = 0; k < 150; k++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            run_op(3'(op), ra, rb, 1'b0);
         end

      // 32-bit mode: word illegal, other ops normal (R8)
      for (int op = 0; op < 5; op++)
         for (int i = 0; i < 9; i += 2)
            run_op(3'(op), corner[i], corner[8 - i], 1'b1);

      // reserved codes (R9)
      for (int op = 5; op < 8; op++) begin
         run_op(3'(op), corner[7], corner[4], 1'b0);
         run_op(3'(op), corner[2], corner[3], 1'b1);
      end

      // R10: start while busy is ignored
      @(negedge clk);
      start_i = 1'b1; op_i = 3'd3; a_i = corner[2]; b_i = corner[2]; mode32_i = 1'b0;
      @(negedge clk);
      op_i = 3'd0; a_i = 64'd3; b_i = 64'd5;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check64("R10 done timing kept", {63'd0, done_o}, 64'd0);
      @(negedge clk);
      check64("R10 done timing kept", {63'd0, done_o}, 64'd1);
      check64("R10 first op result", result_o, ref_res(3'd3, corner[2], corner[2], 1'b0));
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         check64("R10 no extra done", {63'd0, done_o}, 64'd0);
      end

      // R11: result holds between completions
      keep_r = result_o;
      @(negedge clk);
      start_i = 1'b1; op_i = 3'd0; a_i = 64'd7; b_i = 64'd9;
      @(negedge clk);
      start_i = 1'b0;
      for (int k = 0; k < 3; k++) begin
         check64("R11 result held", result_o, keep_r);
         @(negedge clk);
      end
      @(negedge clk);
      check64("R11 new result", result_o, 64'd63);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check64("R11 result held after done", result_o, 64'd63);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule